// File: doc/BRIEF.md
# Level-Triggered GPIO Interrupt Selector

This block turns up to eight chosen GPIO pins into interrupt sources. The pins of all ports are seen as one flat vector cut into byte-wide groups. Each of the eight channels has a fixed lane inside a byte, so channel k always looks at bit k of a byte group, and software picks that group per channel with a 4-bit selector. A group index is the port number times the bytes per port plus the byte within the port, so any byte lane of a wide multi-port GPIO can be covered.

Every pin is first passed through a two-flop synchronizer. A channel then compares its pin with a programmed level, high or low. A match sets a sticky pending bit, which stays set until software writes a one to the acknowledge register. The pending bits are gated by a mask register. The OR of the masked bits drives one registered interrupt request.

Software reaches the block through a flat register strobe: an address, a write enable, write data, and read data that follows the address at once. The same mask register also keeps two enable bits for two unrelated interrupt sources. This block stores those bits and drives them out unchanged.

Top module: `gpio_irq_sel`

## Requirements
- R1: After reset the trigger, selector and mask registers read 0, the masked status reads 0, `irq_o` is 0 and `aux_en_o` is 0.
- R2: Channel k watches the synchronized pin at flat index 8*g+k. Here g is the selector field at bits [4k+3:4k] of address 1. A group whose pins lie beyond the pin vector reads as 0.
- R3: The trigger code for channel k sits at bits [3k+2:3k] of address 0. Code 1 matches a high pin, code 2 matches a low pin, and codes 0 and 3 to 7 never match. Read-back bits [31:24] are 0.
- R4: A pending bit sets on any clock edge at which its channel matches. It stays set after the pin stops matching. A pin change driven between edges shows in the pending bit after the third rising edge, not after the second.
- R5: Writing address 3 clears pending bit k for each data bit k that is 1, and leaves bits written 0 unchanged. If an acknowledge lands on an edge where the channel still matches, the bit stays set.
- R6: Address 4 reads the pending bits AND mask bits [7:0]. Pending bits still latch while masked and appear in the read once unmasked.
- R7: The mask at address 2 keeps bits [9:0]. Bits [9:8] drive `aux_en_o` and read back, and bits [31:10] read 0.
- R8: `irq_o` is a register that goes to the OR of the masked status one edge after that status changes.
- R9: Reads of address 3 and of addresses 5 to 7 return 0. A write to address 4 changes nothing.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| pins_i | input | NUM_PORTS*PORT_BYTES*8 | Raw GPIO input pins of all ports, port 0 in the low bits |
| wr_en_i | input | 1 | Register write strobe |
| addr_i | input | 3 | Register address |
| wdata_i | input | 32 | Register write data |
| rdata_o | output | 32 | Read data for `addr_i` |
| aux_en_o | output | 2 | Enable bits for the two other interrupt sources |
| irq_o | output | 1 | Combined interrupt request |

## Verification
The bench builds the block with NUM_PORTS=3 and PORT_BYTES=4. That gives 96 pins and twelve real groups, while the 4-bit selector can still name groups 12 to 15. This setup lets the bench check that a group past the pin vector reads as a constant 0: a low-level trigger on it fires and a high-level trigger never does. A vector table runs each channel lane against groups spread over all three ports and against every class of trigger code. Directed tests then check the three-edge synchronizer latency, acknowledge racing a live match, and the one-edge lag of the request behind an unmask.

// File: rtl/gpio_irq_pkg.sv
package gpio_irq_pkg;

  localparam int NUM_CH  = 8;
  localparam int CODE_W  = 3;
  localparam int GRP_W   = 4;
  localparam int NUM_GRP = 1 << GRP_W;
  localparam int PAD_W   = NUM_GRP * 8;
  localparam int MASK_W  = NUM_CH + 2;
  localparam int DATA_W  = 32;

  typedef enum logic [2:0] {
    A_TRIG   = 3'd0,
    A_SEL    = 3'd1,
    A_MASK   = 3'd2,
    A_ACK    = 3'd3,
    A_STATUS = 3'd4
  } reg_addr_e;

  typedef enum logic [CODE_W-1:0] {
    TRIG_OFF  = 3'd0,
    TRIG_HIGH = 3'd1,
    TRIG_LOW  = 3'd2
  } trig_code_e;

  function automatic logic [CODE_W-1:0] code_of(
    input logic [NUM_CH*CODE_W-1:0] cfg, input int k);
    return cfg[k*CODE_W +: CODE_W];
  endfunction

  function automatic logic [GRP_W-1:0] group_of(
    input logic [NUM_CH*GRP_W-1:0] sel, input int k);
    return sel[k*GRP_W +: GRP_W];
  endfunction

  function automatic logic level_hit(input logic [CODE_W-1:0] code,
                                     input logic pin);
    logic hit;
    case (code)
      TRIG_HIGH: hit = pin;
      TRIG_LOW:  hit = ~pin;
      default:   hit = 1'b0;
    endcase
    return hit;
  endfunction

endpackage

// File: rtl/gpio_irq_sync.sv
module gpio_irq_sync #(
  parameter int W = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] stage1_q;
  logic [W-1:0] stage2_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      stage1_q <= '0;
      stage2_q <= '0;
    end else begin
      stage1_q <= d_i;
      stage2_q <= stage1_q;
    end
  end

  assign q_o = stage2_q;
endmodule

// File: rtl/gpio_irq_chan.sv
module gpio_irq_chan
  import gpio_irq_pkg::*;
#(
  parameter int CH = 0
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [PAD_W-1:0]  pins_i,
  input  logic [GRP_W-1:0]  group_i,
  input  logic [CODE_W-1:0] code_i,
  input  logic              ack_i,
  output logic              match_o,
  output logic              pending_o
);
  localparam logic [2:0] LANE = 3'(CH);

  logic pin_w;
  logic pending_q;

  assign pin_w   = pins_i[{group_i, LANE}];
  assign match_o = level_hit(code_i, pin_w);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) pending_q <= 1'b0;
    else         pending_q <= (pending_q & ~ack_i) | match_o;
  end

  assign pending_o = pending_q;
endmodule

// File: rtl/gpio_irq_regs.sv
module gpio_irq_regs
  import gpio_irq_pkg::*;
(
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic                     wr_en_i,
  input  logic [2:0]               addr_i,
  input  logic [DATA_W-1:0]        wdata_i,
  input  logic [NUM_CH-1:0]        pending_i,
  output logic [DATA_W-1:0]        rdata_o,
  output logic [NUM_CH*CODE_W-1:0] trig_o,
  output logic [NUM_CH*GRP_W-1:0]  sel_o,
  output logic [MASK_W-1:0]        mask_o,
  output logic [NUM_CH-1:0]        ack_o
);
  localparam int TRIG_W = NUM_CH * CODE_W;
  localparam int SEL_W  = NUM_CH * GRP_W;

  logic [TRIG_W-1:0] trig_q;
  logic [SEL_W-1:0]  sel_q;
  logic [MASK_W-1:0] mask_q;
  logic [NUM_CH-1:0] status_w;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      trig_q <= '0;
      sel_q  <= '0;
      mask_q <= '0;
    end else if (wr_en_i) begin
      case (addr_i)
        A_TRIG: trig_q <= wdata_i[TRIG_W-1:0];
        A_SEL:  sel_q  <= wdata_i[SEL_W-1:0];
        A_MASK: mask_q <= wdata_i[MASK_W-1:0];
        default: ;
      endcase
    end
  end

  assign ack_o    = (wr_en_i && addr_i == A_ACK) ? wdata_i[NUM_CH-1:0] : '0;
  assign status_w = pending_i & mask_q[NUM_CH-1:0];

  always_comb begin
    rdata_o = '0;
    case (addr_i)
      A_TRIG:   rdata_o = DATA_W'(trig_q);
      A_SEL:    rdata_o = DATA_W'(sel_q);
      A_MASK:   rdata_o = DATA_W'(mask_q);
      A_STATUS: rdata_o = DATA_W'(status_w);
      default:  rdata_o = '0;
    endcase
  end

  assign trig_o = trig_q;
  assign sel_o  = sel_q;
  assign mask_o = mask_q;
endmodule

// File: rtl/gpio_irq_sel.sv
module gpio_irq_sel
  import gpio_irq_pkg::*;
#(
  parameter int NUM_PORTS  = 4,
  parameter int PORT_BYTES = 4
) (
  input  logic                            clk_i,
  input  logic                            rst_ni,
  input  logic [NUM_PORTS*PORT_BYTES*8-1:0] pins_i,
  input  logic                            wr_en_i,
  input  logic [2:0]                      addr_i,
  input  logic [31:0]                     wdata_i,
  output logic [31:0]                     rdata_o,
  output logic [1:0]                      aux_en_o,
  output logic                            irq_o
);
  localparam int NUM_PINS = NUM_PORTS * PORT_BYTES * 8;

  logic [NUM_PINS-1:0]        pins_sync_w;
  logic [PAD_W-1:0]           pins_pad_w;
  logic [NUM_CH*CODE_W-1:0]   trig_w;
  logic [NUM_CH*GRP_W-1:0]    sel_w;
  logic [MASK_W-1:0]          mask_w;
  logic [NUM_CH-1:0]          ack_w;
  logic [NUM_CH-1:0]          match_w;
  logic [NUM_CH-1:0]          pending_w;
  logic                       irq_q;

  gpio_irq_sync #(.W(NUM_PINS)) u_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .d_i    (pins_i),
    .q_o    (pins_sync_w)
  );

  assign pins_pad_w = PAD_W'(pins_sync_w);

  gpio_irq_regs u_regs (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .wr_en_i   (wr_en_i),
    .addr_i    (addr_i),
    .wdata_i   (wdata_i),
    .pending_i (pending_w),
    .rdata_o   (rdata_o),
    .trig_o    (trig_w),
    .sel_o     (sel_w),
    .mask_o    (mask_w),
    .ack_o     (ack_w)
  );

  for (genvar k = 0; k < NUM_CH; k++) begin : g_chan
    gpio_irq_chan #(.CH(k)) u_chan (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .pins_i    (pins_pad_w),
      .group_i   (group_of(sel_w, k)),
      .code_i    (code_of(trig_w, k)),
      .ack_i     (ack_w[k]),
      .match_o   (match_w[k]),
      .pending_o (pending_w[k])
    );
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) irq_q <= 1'b0;
    else         irq_q <= |(pending_w & mask_w[NUM_CH-1:0]);
  end

  assign irq_o    = irq_q;
  assign aux_en_o = mask_w[MASK_W-1:NUM_CH];
endmodule

// File: rtl/gpio_irq_sel_chk.sv
module gpio_irq_sel_chk (
  input logic        clk_i,
  input logic        rst_ni,
  input logic [2:0]  addr_i,
  input logic [31:0] rdata_o,
  input logic        irq_o,
  input logic [7:0]  match_w,
  input logic [7:0]  ack_w,
  input logic [7:0]  pending_w,
  input logic [9:0]  mask_w
);
  // R4: an unacknowledged pending bit never drops
  p_hold_pending_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> ((pending_w & $past(pending_w & ~ack_w)) == $past(pending_w & ~ack_w)));

  // R5: a match wins over a same-edge acknowledge
  p_match_sets_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> ((pending_w & $past(match_w)) == $past(match_w)));

  // R5: a pending bit only falls after an acknowledge of that bit
  p_clear_by_ack_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> ((~pending_w & $past(pending_w) & ~$past(ack_w)) == 8'h00));

  // R8: request follows masked status by one edge
  p_irq_lag_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> (irq_o == $past(|(pending_w & mask_w[7:0]))));

  // R6: status read shows only masked pending bits
  p_status_read_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (addr_i == 3'd4) |-> (rdata_o[7:0] == (pending_w & mask_w[7:0]) && rdata_o[31:8] == 24'h0));

  // R9: acknowledge address reads zero
  p_ack_reads_zero_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (addr_i == 3'd3) |-> (rdata_o == 32'h0));
endmodule

bind gpio_irq_sel gpio_irq_sel_chk u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .addr_i    (addr_i),
  .rdata_o   (rdata_o),
  .irq_o     (irq_o),
  .match_w   (match_w),
  .ack_w     (ack_w),
  .pending_w (pending_w),
  .mask_w    (mask_w)
);

// File: tb/gpio_irq_sel_tb.sv
`timescale 1ns/1ps
module gpio_irq_sel_tb;
  localparam int NP = 3;
  localparam int PB = 4;
  localparam int NPINS = NP * PB * 8;

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic [NPINS-1:0] pins = '0;
  logic             wr_en = 1'b0;
  logic [2:0]       addr = 3'd0;
  logic [31:0]      wdata = '0;
  logic [31:0]      rdata;
  logic [1:0]       aux_en;
  logic             irq;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  gpio_irq_sel #(.NUM_PORTS(NP), .PORT_BYTES(PB)) u_dut (
    .clk_i(clk), .rst_ni(rst_n), .pins_i(pins), .wr_en_i(wr_en),
    .addr_i(addr), .wdata_i(wdata), .rdata_o(rdata),
    .aux_en_o(aux_en), .irq_o(irq)
  );

  // {channel[3], group[4], code[3], pin level[1], expected pending[1]}
  localparam int NV = 13;
  localparam logic [11:0] VEC [NV] = '{
    {3'd0, 4'd0,  3'd1, 1'b1, 1'b1},
    {3'd0, 4'd0,  3'd1, 1'b0, 1'b0},
    {3'd3, 4'd5,  3'd2, 1'b0, 1'b1},
    {3'd3, 4'd5,  3'd2, 1'b1, 1'b0},
    {3'd7, 4'd11, 3'd1, 1'b1, 1'b1},
    {3'd7, 4'd11, 3'd0, 1'b1, 1'b0},
    {3'd5, 4'd2,  3'd4, 1'b1, 1'b0},
    {3'd5, 4'd2,  3'd7, 1'b0, 1'b0},
    {3'd2, 4'd13, 3'd2, 1'b1, 1'b1},
    {3'd2, 4'd13, 3'd1, 1'b1, 1'b0},
    {3'd6, 4'd8,  3'd1, 1'b1, 1'b1},
    {3'd1, 4'd4,  3'd3, 1'b0, 1'b0},
    {3'd4, 4'd9,  3'd2, 1'b0, 1'b1}
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk);
    wr_en = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    wr_en = 1'b0; wdata = '0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [31:0] v);
    addr = a;
    #1;
    v = rdata;
  endtask

  task automatic cleanup();
    wr(3'd0, 32'h0);
    pins = '0;
    wr(3'd3, 32'hFF);
  endtask

  initial begin
    logic [31:0] v;
    repeat (3) @(negedge clk);
    // R1: reset state
    rd(3'd0, v); chk("R1 trig", v, 32'h0);
    rd(3'd1, v); chk("R1 sel", v, 32'h0);
    rd(3'd2, v); chk("R1 mask", v, 32'h0);
    rd(3'd4, v); chk("R1 status", v, 32'h0);
    chk("R1 irq", {31'h0, irq}, 32'h0);
    chk("R1 aux", {30'h0, aux_en}, 32'h0);
    rst_n = 1'b1;
    @(negedge clk);

    // table walk: R2 and R3
    for (int i = 0; i < NV; i++) begin
      logic [2:0] ch; logic [3:0] grp; logic [2:0] code; logic pv, ex;
      int idx;
      logic [NPINS-1:0] one;
      {ch, grp, code, pv, ex} = VEC[i];
      idx = int'(grp) * 8 + int'(ch);
      one = (idx < NPINS) ? (NPINS'(1) << idx) : '0;
      wr(3'd1, 32'(grp) << (4 * ch));
      wr(3'd2, 32'h0FF);
      pins = pv ? one : ~one;
      repeat (3) @(negedge clk);
      wr(3'd0, 32'(code) << (3 * ch));
      @(negedge clk);
      rd(3'd4, v); chk("R2 R3 table status", v, 32'(ex) << ch);
      @(negedge clk);
      chk("R3 table irq", {31'h0, irq}, {31'h0, ex});
      cleanup();
    end

    // R3: code read-back keeps only 24 bits
    wr(3'd0, 32'hFFFF_FFFF);
    rd(3'd0, v); chk("R3 trig readback", v, 32'h00FF_FFFF);
    wr(3'd0, 32'h0);
    wr(3'd3, 32'hFF);

    // R4: three-edge latency and latching (channel 1, group 6 = port 1 byte 2)
    wr(3'd1, 32'h0000_0060);
    wr(3'd0, 32'h0000_0008);
    wr(3'd2, 32'h0FF);
    pins[6*8+1] = 1'b1;
    @(negedge clk); @(negedge clk);
    rd(3'd4, v); chk("R4 not yet after two edges", v, 32'h0);
    @(negedge clk);
    rd(3'd4, v); chk("R4 set after third edge", v, 32'h2);
    pins[6*8+1] = 1'b0;
    repeat (4) @(negedge clk);
    rd(3'd4, v); chk("R4 latched after pin drops", v, 32'h2);

    // R5: zero bits of acknowledge leave pending alone
    wr(3'd3, 32'hFD);
    rd(3'd4, v); chk("R5 ack zero bit kept", v, 32'h2);
    wr(3'd3, 32'h02);
    rd(3'd4, v); chk("R5 ack clears", v, 32'h0);
    // R5: acknowledge while pin still matches
    pins[6*8+1] = 1'b1;
    repeat (3) @(negedge clk);
    wr(3'd3, 32'h02);
    rd(3'd4, v); chk("R5 ack vs live match", v, 32'h2);
    cleanup();

    // R6 and R8: latch while masked, then unmask
    wr(3'd2, 32'h0);
    wr(3'd1, 32'h0);
    wr(3'd0, 32'h0000_0002 << 3*4);  // channel 4 low level, group 0
    repeat (3) @(negedge clk);
    rd(3'd4, v); chk("R6 masked status", v, 32'h0);
    chk("R6 masked irq", {31'h0, irq}, 32'h0);
    wr(3'd2, 32'h010);
    rd(3'd4, v); chk("R6 unmasked status", v, 32'h10);
    chk("R8 irq one edge later", {31'h0, irq}, 32'h0);
    @(negedge clk);
    chk("R8 irq raised", {31'h0, irq}, 32'h1);
    wr(3'd2, 32'h0);
    @(negedge clk);
    chk("R8 irq drops", {31'h0, irq}, 32'h0);

    // R9: status is read-only; address 3 and 5..7 read zero
    wr(3'd4, 32'h0);
    wr(3'd2, 32'h010);
    rd(3'd4, v); chk("R9 status write ignored", v, 32'h10);
    rd(3'd3, v); chk("R9 ack reads zero", v, 32'h0);
    for (int a = 5; a < 8; a++) begin
      rd(3'(a), v); chk("R9 spare reads zero", v, 32'h0);
    end
    cleanup();

    // R7: mask width and aux enables
    wr(3'd2, 32'hFFFF_FFFF);
    rd(3'd2, v); chk("R7 mask readback", v, 32'h3FF);
    chk("R7 aux both", {30'h0, aux_en}, 32'h3);
    wr(3'd2, 32'h1FF);
    chk("R7 aux low", {30'h0, aux_en}, 32'h1);
    rd(3'd4, v); chk("R7 aux leaves status", v, 32'h0);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule